// File: doc/BRIEF.md
# PHY Management Register Access Sequencer

This block sits between a management client and a frame engine that serialises single MDIO register transactions. The client asks for one operation on one PHY register: a read, a write, or a read-modify-write. It supplies a 5-bit PHY address, a 16-bit register number, write data and a pair of bit masks. The block breaks that request into the register transactions it needs and hands them to the engine one at a time. When the last step finishes, or a step fails, it raises a single done pulse.

A register number of 0x001F or less fits the 5-bit register field of a management frame, so it is accessed directly. A larger number is reached through an indirect pair of registers: a control register at 0x000D and an address/data window at 0x000E. A fixed four-step sequence selects the target register and then moves the data through the window. A read-modify-write reuses the same path. After the read of the window, the merged value is written back through that window without selecting the register again.

Top module: `phy_reg_sequencer`

## Requirements
- R1: Request operation codes are 0 = read, 1 = write, 2 = read-modify-write, and 3 behaves as a read. A read of a register number of 0x001F or less issues exactly one read command to that register. rdData then returns the engine's response data.
- R2: A write to a register number of 0x001F or less issues exactly one write command of reqWdata to that register.
- R3: A register number above 0x001F starts with three writes, in this order: 0x001F to register 0x000D, the register number to register 0x000E, and 0x401F to register 0x000D. The data step that follows targets register 0x000E.
- R4: An indirect read ends with a read of 0x000E, and the data of that read is returned on rdData. An indirect write ends with a write of reqWdata to 0x000E.
- R5: A read-modify-write reads the target and then writes (old & ~reqClr) | reqSet to the same register, so a set bit wins over a clear bit. The direct form uses 2 commands and the indirect form uses 5 (the three setup writes, a read of 0x000E, then a write of 0x000E). rdData returns the old value.
- R6: At most one command is outstanding. cmdValid does not rise again until the response to the previous command has arrived. While cmdValid is high and cmdReady is low, the command fields do not change.
- R7: busy rises in the cycle after a request is accepted and stays high until the done cycle. A reqValid that arrives while busy is high is ignored and starts no commands.
- R8: A response with rspErr set ends the sequence at once. No further command is issued, and done rises together with doneErr.
- R9: done is a one-cycle pulse, and busy is low in the following cycle. rdData reads 0 after a write request, and also after reset.
- R10: Every command carries the PHY address of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 2 | Operation code |
| reqPhy | input | 5 | Target PHY address |
| reqRegNum | input | 16 | Target register number |
| reqWdata | input | 16 | Data for a write |
| reqSet | input | 16 | Bits forced to 1 by a read-modify-write |
| reqClr | input | 16 | Bits forced to 0 by a read-modify-write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Qualifies done: the sequence aborted |
| rdData | output | 16 | Value read by the request |
| cmdValid | output | 1 | Command offered to the engine |
| cmdReady | input | 1 | Engine takes the command |
| cmdWrite | output | 1 | 1 = write command, 0 = read command |
| cmdPhy | output | 5 | Command PHY address |
| cmdReg | output | 5 | Command register field |
| cmdWdata | output | 16 | Command write data |
| rspValid | input | 1 | Engine finished the taken command |
| rspErr | input | 1 | Engine reports a failed command |
| rspData | input | 16 | Engine read data |

## Verification
The assertions assume the engine raises rspValid only for a command it has taken, no earlier than the cycle after the handshake, with exactly one pulse per command. They also assume the engine never pulses rspValid while no command is outstanding. The bench's engine model keeps to this: it raises cmdReady after a programmed delay, and it answers after a programmed latency of at least one cycle. Requests sent while busy is high are dropped before done, so they cannot be taken legally when the block returns to idle.

// File: rtl/physeq_pkg.sv
`timescale 1ns/1ps
package physeq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_ALTRD = 2'd3
  } reqOp_e;

  typedef enum logic [2:0] {
    K_SEL_ADDR,
    K_PUT_ADDR,
    K_SEL_DATA,
    K_READ,
    K_WRITE
  } stepKind_e;

  typedef struct packed {
    logic      load;
    logic      capRead;
    stepKind_e kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/physeq_ctrl.sv
`timescale 1ns/1ps
module physeq_ctrl
  import physeq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  reqOp_e      reqOp,
  input  logic        reqExt,
  input  reqOp_e      opQ,
  input  logic        cmdReady,
  input  logic        rspValid,
  input  logic        rspErr,
  output ctrlStrobe_t strb,
  output logic        cmdValid,
  output logic        busy,
  output logic        done,
  output logic        doneErr
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_e;

  state_e    state;
  stepKind_e kindQ;
  stepKind_e firstKind;
  stepKind_e nextKind;
  logic      errQ;
  logic      lastStep;
  logic      accept;

  assign accept = (state == S_IDLE) && reqValid;

  always_comb begin
    if (reqExt)                 firstKind = K_SEL_ADDR;
    else if (reqOp == OP_WRITE) firstKind = K_WRITE;
    else                        firstKind = K_READ;
  end

  always_comb begin
    nextKind = K_WRITE;
    lastStep = 1'b0;
    unique case (kindQ)
      K_SEL_ADDR: nextKind = K_PUT_ADDR;
      K_PUT_ADDR: nextKind = K_SEL_DATA;
      K_SEL_DATA: nextKind = (opQ == OP_WRITE) ? K_WRITE : K_READ;
      K_READ:     lastStep = (opQ != OP_RMW);
      K_WRITE:    lastStep = 1'b1;
      default:    lastStep = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_READ;
      errQ  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state <= S_ISSUE;
          kindQ <= firstKind;
          errQ  <= 1'b0;
        end
        S_ISSUE: if (cmdReady) state <= S_WAIT;
        S_WAIT: if (rspValid) begin
          if (rspErr) begin
            errQ  <= 1'b1;
            state <= S_FIN;
          end else if (lastStep) begin
            state <= S_FIN;
          end else begin
            kindQ <= nextKind;
            state <= S_ISSUE;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strb.load    = accept;
  assign strb.capRead = (state == S_WAIT) && rspValid && !rspErr && (kindQ == K_READ);
  assign strb.kind    = kindQ;
  assign cmdValid     = (state == S_ISSUE);
  assign busy         = (state != S_IDLE);
  assign done         = (state == S_FIN);
  assign doneErr      = done && errQ;

  // R6: a command once offered stays offered until taken
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid);

  // R7: busy only starts after a request strobe
  a_r7_busy_from_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R9: done lasts one cycle and the block is idle afterwards
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R8: an engine error leads straight to an error completion
  a_r8_err_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) && rspValid && rspErr |=> done && doneErr && !cmdValid);
endmodule

// File: rtl/physeq_dpath.sv
`timescale 1ns/1ps
module physeq_dpath
  import physeq_pkg::*;
#(
  parameter int PHY_W     = 5,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16,
  parameter int REQ_REG_W = 16,
  parameter logic [REG_W-1:0]  CTRL_REG  = 5'h0D,
  parameter logic [REG_W-1:0]  DATA_REG  = 5'h0E,
  parameter logic [DATA_W-1:0] ADDR_WORD = 16'h001F,
  parameter logic [DATA_W-1:0] DATA_WORD = 16'h401F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [PHY_W-1:0]     reqPhy,
  input  logic [REQ_REG_W-1:0] reqRegNum,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    reqSet,
  input  logic [DATA_W-1:0]    reqClr,
  input  reqOp_e               reqOp,
  input  logic [DATA_W-1:0]    rspData,
  output logic                 reqExt,
  output reqOp_e               opQ,
  output logic                 extQ,
  output logic                 cmdWrite,
  output logic [PHY_W-1:0]     cmdPhy,
  output logic [REG_W-1:0]     cmdReg,
  output logic [DATA_W-1:0]    cmdWdata,
  output logic [DATA_W-1:0]    rdData
);
  localparam logic [REQ_REG_W-1:0] DIRECT_MAX = REQ_REG_W'((1 << REG_W) - 1);

  logic [PHY_W-1:0]     phyQ;
  logic [REQ_REG_W-1:0] regNumQ;
  logic [DATA_W-1:0]    wdQ, setQ, clrQ, rdQ;
  logic [REG_W-1:0]     dataReg;
  logic [DATA_W-1:0]    merged;

  assign reqExt = reqRegNum > DIRECT_MAX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyQ    <= '0;
      regNumQ <= '0;
      wdQ     <= '0;
      setQ    <= '0;
      clrQ    <= '0;
      opQ     <= OP_READ;
      extQ    <= 1'b0;
      rdQ     <= '0;
    end else if (strb.load) begin
      phyQ    <= reqPhy;
      regNumQ <= reqRegNum;
      wdQ     <= reqWdata;
      setQ    <= reqSet;
      clrQ    <= reqClr;
      opQ     <= reqOp;
      extQ    <= reqExt;
      rdQ     <= '0;
    end else if (strb.capRead) begin
      rdQ     <= rspData;
    end
  end

  assign dataReg = extQ ? DATA_REG : regNumQ[REG_W-1:0];
  assign merged  = (rdQ & ~clrQ) | setQ;

  always_comb begin
    cmdWrite = 1'b1;
    cmdReg   = dataReg;
    cmdWdata = '0;
    unique case (strb.kind)
      K_SEL_ADDR: begin cmdReg = CTRL_REG; cmdWdata = ADDR_WORD; end
      K_PUT_ADDR: begin cmdReg = DATA_REG; cmdWdata = DATA_W'(regNumQ); end
      K_SEL_DATA: begin cmdReg = CTRL_REG; cmdWdata = DATA_WORD; end
      K_READ:     cmdWrite = 1'b0;
      K_WRITE:    cmdWdata = (opQ == OP_RMW) ? merged : wdQ;
      default:    cmdWrite = 1'b0;
    endcase
  end

  assign cmdPhy = phyQ;
  assign rdData = rdQ;

  // R9: a new request clears the returned data
  a_r9_rd_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> rdData == '0);

  // R5: the write-back of a merge keeps every requested set bit
  a_r5_set_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.kind == K_WRITE) && (opQ == OP_RMW) |-> (cmdWdata & setQ) == setQ);
endmodule

// File: rtl/phy_reg_sequencer.sv
`timescale 1ns/1ps
module phy_reg_sequencer
  import physeq_pkg::*;
#(
  parameter int PHY_W     = 5,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16,
  parameter int REQ_REG_W = 16,
  parameter logic [REG_W-1:0]  CTRL_REG  = 5'h0D,
  parameter logic [REG_W-1:0]  DATA_REG  = 5'h0E,
  parameter logic [DATA_W-1:0] ADDR_WORD = 16'h001F,
  parameter logic [DATA_W-1:0] DATA_WORD = 16'h401F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [PHY_W-1:0]     reqPhy,
  input  logic [REQ_REG_W-1:0] reqRegNum,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    reqSet,
  input  logic [DATA_W-1:0]    reqClr,
  output logic                 busy,
  output logic                 done,
  output logic                 doneErr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 cmdValid,
  input  logic                 cmdReady,
  output logic                 cmdWrite,
  output logic [PHY_W-1:0]     cmdPhy,
  output logic [REG_W-1:0]     cmdReg,
  output logic [DATA_W-1:0]    cmdWdata,
  input  logic                 rspValid,
  input  logic                 rspErr,
  input  logic [DATA_W-1:0]    rspData
);
  ctrlStrobe_t strb;
  reqOp_e      opQ;
  logic        reqExt;
  logic        extQ;

  physeq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp_e'(reqOp)),
    .reqExt(reqExt), .opQ(opQ), .cmdReady(cmdReady), .rspValid(rspValid),
    .rspErr(rspErr), .strb(strb), .cmdValid(cmdValid), .busy(busy),
    .done(done), .doneErr(doneErr)
  );

  physeq_dpath #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .REQ_REG_W(REQ_REG_W),
    .CTRL_REG(CTRL_REG), .DATA_REG(DATA_REG),
    .ADDR_WORD(ADDR_WORD), .DATA_WORD(DATA_WORD)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqPhy(reqPhy), .reqRegNum(reqRegNum),
    .reqWdata(reqWdata), .reqSet(reqSet), .reqClr(reqClr), .reqOp(reqOp_e'(reqOp)),
    .rspData(rspData), .reqExt(reqExt), .opQ(opQ), .extQ(extQ),
    .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdReg(cmdReg),
    .cmdWdata(cmdWdata), .rdData(rdData)
  );

  // R3: during an indirect sequence only the pair registers are touched, and the control one only by writes
  a_r3_pair_only: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && extQ |-> (cmdReg == CTRL_REG && cmdWrite) || cmdReg == DATA_REG);

  // R6: command fields hold while the engine stalls
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable(cmdReg) && $stable(cmdWdata) && $stable(cmdWrite));
endmodule

// File: tb/phy_reg_sequencer_tb.sv
`timescale 1ns/1ps
module phy_reg_sequencer_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, reqValid, busy, done, doneErr, cmdValid, cmdReady, cmdWrite;
  logic rspValid, rspErr;
  logic [1:0]  reqOp;
  logic [4:0]  reqPhy, cmdPhy, cmdReg;
  logic [15:0] reqRegNum, reqWdata, reqSet, reqClr, rdData, cmdWdata, rspData;

  phy_reg_sequencer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPhy(reqPhy),
    .reqRegNum(reqRegNum), .reqWdata(reqWdata), .reqSet(reqSet), .reqClr(reqClr),
    .busy(busy), .done(done), .doneErr(doneErr), .rdData(rdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite), .cmdPhy(cmdPhy),
    .cmdReg(cmdReg), .cmdWdata(cmdWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [15:0] regn, wd, setm, clrm, rv;
    logic [3:0]  rdy, lat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'h01, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h796D, 4'd0, 4'd1},
    '{2'd1, 5'h03, 16'h001F, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 4'd2, 4'd1},
    '{2'd0, 5'h0C, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 16'hBEEF, 4'd0, 4'd3},
    '{2'd1, 5'h0F, 16'h0031, 16'hA5A5, 16'h0000, 16'h0000, 16'h0000, 4'd1, 4'd2},
    '{2'd2, 5'h1F, 16'h0010, 16'h0000, 16'h0003, 16'hF000, 16'hF0F0, 4'd0, 4'd1},
    '{2'd2, 5'h01, 16'h0031, 16'h0000, 16'h0001, 16'h0060, 16'h0070, 4'd3, 4'd2},
    '{2'd2, 5'h00, 16'h0004, 16'h0000, 16'h0800, 16'h0C00, 16'h0DE1, 4'd1, 4'd1}
  };

  int checks = 0;
  int fails  = 0;

  // engine model state
  int rdyDly, lat, errAt, cmdCount, pendCnt, waitCnt, ovlFail, stabFail;
  logic [15:0] readVal;
  logic        held;
  logic [26:0] heldVal;
  logic        recW [8];
  logic [4:0]  recR [8];
  logic [4:0]  recP [8];
  logic [15:0] recD [8];

  // expected sequence
  int          exN;
  logic [15:0] exRd;
  logic        exW [8];
  logic [4:0]  exR [8];
  logic [15:0] exD [8];

  task automatic chk(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    cmdReady = 1'b0; rspValid = 1'b0; rspErr = 1'b0; rspData = '0;
    pendCnt = 0; waitCnt = 0; held = 1'b0; cmdCount = 0;
    ovlFail = 0; stabFail = 0; errAt = -1; rdyDly = 0; lat = 1; readVal = '0;
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      rspErr   = 1'b0;
      cmdReady = 1'b0;
      if (!rstN) begin
        pendCnt = 0; waitCnt = 0; held = 1'b0;
      end else begin
        if (cmdValid && pendCnt > 0) ovlFail++;
        if (pendCnt > 0) begin
          pendCnt--;
          if (pendCnt == 0) begin
            rspValid = 1'b1;
            rspErr   = (cmdCount - 1 == errAt);
            rspData  = readVal;
          end
        end else if (cmdValid) begin
          if (held && {cmdWrite, cmdReg, cmdPhy, cmdWdata} != heldVal) stabFail++;
          if (waitCnt >= rdyDly) begin
            cmdReady = 1'b1;
            if (cmdCount < 8) begin
              recW[cmdCount] = cmdWrite;
              recR[cmdCount] = cmdReg;
              recP[cmdCount] = cmdPhy;
              recD[cmdCount] = cmdWdata;
            end
            cmdCount++;
            pendCnt = lat;
            waitCnt = 0;
            held    = 1'b0;
          end else begin
            waitCnt++;
            held    = 1'b1;
            heldVal = {cmdWrite, cmdReg, cmdPhy, cmdWdata};
          end
        end
      end
    end
  end

  task automatic addExp(input logic w, input logic [4:0] r, input logic [15:0] d);
    exW[exN] = w; exR[exN] = r; exD[exN] = d; exN++;
  endtask

  task automatic buildExp(input vec_t v);
    logic [4:0] fr;
    exN  = 0;
    fr   = v.regn[4:0];
    if (v.regn > 16'h001F) begin
      addExp(1'b1, 5'h0D, 16'h001F);
      addExp(1'b1, 5'h0E, v.regn);
      addExp(1'b1, 5'h0D, 16'h401F);
      fr = 5'h0E;
    end
    if (v.op == 2'd1) begin
      addExp(1'b1, fr, v.wd);
      exRd = 16'h0000;
    end else if (v.op == 2'd2) begin
      addExp(1'b0, fr, 16'h0000);
      addExp(1'b1, fr, (v.rv & ~v.clrm) | v.setm);
      exRd = v.rv;
    end else begin
      addExp(1'b0, fr, 16'h0000);
      exRd = v.rv;
    end
  endtask

  task automatic runReq(input vec_t v, input int errIdx, output logic [15:0] rd, output logic er);
    int n;
    rdyDly = v.rdy; lat = v.lat; readVal = v.rv; errAt = errIdx;
    cmdCount = 0; ovlFail = 0; stabFail = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = v.op; reqPhy = v.phy; reqRegNum = v.regn;
    reqWdata = v.wd; reqSet = v.setm; reqClr = v.clrm;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9 done reached", done, 1);
    rd = rdData;
    er = doneErr;
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic checkCmds(input vec_t v, input string tag);
    chk(cmdCount == exN, {tag, " command count"}, cmdCount, exN);
    for (int i = 0; i < exN && i < cmdCount; i++) begin
      chk(recW[i] == exW[i], {tag, " command direction"}, recW[i], exW[i]);
      chk(recR[i] == exR[i], {tag, " command register"}, recR[i], exR[i]);
      chk(recP[i] == v.phy, "R10 command phy address", recP[i], v.phy);
      if (exW[i]) chk(recD[i] == exD[i], {tag, " command data"}, recD[i], exD[i]);
    end
    chk(ovlFail == 0, "R6 one outstanding command", ovlFail, 0);
    chk(stabFail == 0, "R6 fields stable while stalled", stabFail, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        er;
    vec_t        v;
    string       tag;
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqPhy = '0; reqRegNum = '0;
    reqWdata = '0; reqSet = '0; reqClr = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 busy low in reset", busy, 0);
    chk(done == 1'b0, "R9 done low in reset", done, 0);
    chk(cmdValid == 1'b0, "R6 no command in reset", cmdValid, 0);
    chk(rdData == 16'h0, "R9 rdData zero in reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      buildExp(v);
      if (v.regn > 16'h001F) tag = (v.op == 2'd2) ? "R5" : "R3";
      else if (v.op == 2'd1) tag = "R2";
      else if (v.op == 2'd2) tag = "R5";
      else tag = "R1";
      runReq(v, -1, rd, er);
      checkCmds(v, tag);
      if (v.op == 2'd1) chk(rd == exRd, "R9 rdData zero after write", rd, exRd);
      else if (v.op == 2'd2) chk(rd == exRd, "R5 old value returned", rd, exRd);
      else chk(rd == exRd, (v.regn > 16'h001F) ? "R4 indirect read data" : "R1 direct read data", rd, exRd);
      chk(er == 1'b0, "R8 no error flag", er, 0);
    end

    // R4: indirect write ends with a data write to the window
    v = '{2'd1, 5'h03, 16'h00D3, 16'h0BAD, 16'h0, 16'h0, 16'h0, 4'd0, 4'd1};
    buildExp(v);
    runReq(v, -1, rd, er);
    checkCmds(v, "R4");

    // R8: abort during indirect setup
    v = '{2'd0, 5'h0C, 16'h0031, 16'h0, 16'h0, 16'h0, 16'h1111, 4'd0, 4'd2};
    runReq(v, 1, rd, er);
    chk(cmdCount == 2, "R8 abort stops commands", cmdCount, 2);
    chk(er == 1'b1, "R8 error flag on abort", er, 1);
    repeat (5) @(negedge clk);
    chk(cmdCount == 2 && !busy, "R8 nothing after abort", cmdCount, 2);

    // R8: error on a direct write
    v = '{2'd1, 5'h01, 16'h0009, 16'h0300, 16'h0, 16'h0, 16'h0, 4'd1, 4'd1};
    runReq(v, 0, rd, er);
    chk(cmdCount == 1, "R8 single step aborted", cmdCount, 1);
    chk(er == 1'b1, "R8 error flag direct", er, 1);

    // R7: requests while busy are ignored
    v = '{2'd1, 5'h0F, 16'h0031, 16'h0001, 16'h0, 16'h0, 16'h0, 4'd2, 4'd3};
    buildExp(v);
    fork
      runReq(v, -1, rd, er);
      begin
        repeat (3) @(negedge clk);
        reqValid = 1'b1; reqOp = 2'd0; reqRegNum = 16'h0002; reqPhy = 5'h07;
        repeat (2) @(negedge clk);
        reqValid = 1'b0;
      end
    join
    checkCmds(v, "R7");
    chk(rd == 16'h0, "R7 result of the first request", rd, 0);
    repeat (6) @(negedge clk);
    chk(cmdCount == exN, "R7 ignored request issued nothing", cmdCount, exN);
    chk(busy == 1'b0, "R7 stays idle", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule